// File: doc/BRIEF.md
# Regular-Group Conversion Sequencer

This block steps a multi-channel analog-to-digital converter through a group of up to nineteen channels. A bitmask selects which channels take part. Each channel has a fixed place in the order, given by its index. The scan walks that order upward or downward and skips every channel whose bit is clear. A run starts on a software start pulse or on a chosen edge of an external trigger. In single mode one pass is made per trigger. In continuous mode the pass repeats until a stop request. In stepped (discontinuous) mode each trigger converts one channel only.

For every rank the sequencer puts the channel number on `conv_chan` and pulses `conv_start` for one clock. The converter is modelled as an internal counter whose length is the sampling time plus the processing time for the chosen resolution. When that length has run out, the sequencer samples `conv_result`, trims it to the resolution and places it on a valid/ready result port.

The result port follows these rules:
- The word is consumed in any cycle where `dout_valid` and `dout_ready` are both high.
- While the consumer holds `dout_ready` low, the word stays on the port.
- If a new result arrives before the old one is taken, this is an overrun. The keep/overwrite control decides which word survives.
- With auto-wait set, the next conversion is held back until the consumer has taken the word. In that mode overruns cannot occur.

Top module: `rgscan_top`

## Requirements
- R1: With `scan_back`=0, the ranks are converted in ascending channel order. Bit n of `chan_mask` enables channel n, and channels whose bit is clear are skipped.
- R2: With `scan_back`=1, the ranks are converted in descending channel order, with the same skipping.
- R3: `conv_start` is high for exactly one clock per rank, and `conv_chan` names the rank in that cycle. `eoc` rises (S+P)/2+1 clocks after the `conv_start` cycle. S is the sampling length in half clocks for `samp_sel` codes 0..7: 3, 15, 27, 57, 83, 111, 143, 479. P is the processing length in half clocks for `res_sel` 0..3 (12, 10, 8 and 6 bits): 25, 21, 17, 13.
- R4: In single mode (`cont_mode`=0, `disc_mode`=0), one trigger runs one complete pass and the block then returns to idle with `busy` low.
- R5: In continuous mode, the pass restarts from the first enabled rank without a new trigger.
- R6: In stepped mode (`disc_mode`=1, `cont_mode`=0), each trigger converts exactly one rank, and `busy` stays high between triggers. When `cont_mode`=1, `disc_mode` has no effect.
- R7: `trig_edge` selects which edges of `ext_trig` start a run: 0 none, 1 rising, 2 falling, 3 both. `sw_start` always starts a run.
- R8: With `auto_wait`=1, no `conv_start` is issued while an unread result is held on the port.
- R9: A result that completes while `dout_valid` is high and no handshake happens in that cycle pulses `ovr` for one clock. With `ovr_keep`=1 the held word is kept; with `ovr_keep`=0 it is replaced by the new one.
- R10: `eoc` pulses for one clock after every rank. `eos` pulses together with `eoc` for the last enabled rank of a pass. A mask with a single bit set gives one rank with both pulses.
- R11: `dout_data` and `dout_chan` hold steady while `dout_valid` is high and `dout_ready` is low, except when an overrun overwrites them. `dout_valid` falls after a handshake unless a new result lands in the same cycle.
- R12: `stop_req` ends a run at the next rank boundary. A conversion in flight completes and delivers its result, and then `busy` falls.
- R13: The captured word is `conv_result` masked to its low 12, 10, 8 or 6 bits for `res_sel` 0, 1, 2 or 3.
- R14: Triggers that arrive while a run is under way, other than in the stepped-mode wait, are ignored. A trigger with an all-zero mask does not start a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_mask | input | NCH | Channel enables, bit n for channel n |
| scan_back | input | 1 | 1 = descending scan order |
| cont_mode | input | 1 | Repeat the pass continuously |
| disc_mode | input | 1 | One rank per trigger |
| trig_edge | input | 2 | External edge select: none, rise, fall, both |
| res_sel | input | 2 | Resolution: 12, 10, 8 or 6 bits |
| samp_sel | input | 3 | Sampling length code |
| auto_wait | input | 1 | Hold the next conversion until the result is read |
| ovr_keep | input | 1 | On overrun, 1 keeps the old word and 0 overwrites it |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | External trigger level |
| stop_req | input | 1 | Stop at the next rank boundary |
| conv_start | output | 1 | One-clock start pulse to the converter |
| conv_chan | output | CW | Channel being converted |
| conv_result | input | DW | Raw converter output, sampled at the end of a conversion |
| dout_data | output | DW | Result word |
| dout_chan | output | CW | Channel of the result word |
| dout_valid | output | 1 | Result word is valid |
| dout_ready | input | 1 | Consumer takes the word |
| eoc | output | 1 | End-of-conversion pulse |
| eos | output | 1 | End-of-pass pulse |
| ovr | output | 1 | Overrun pulse |
| busy | output | 1 | A run is under way |

## Verification
The bench sends random sparse and dense masks in both scan directions, each with random sampling and resolution codes. Every rank is checked for its place in the order, its latency and its masked data. This separates errors in the rank picker from errors in the timer and the data path. Directed runs cover the other behaviours one at a time: a single-channel mask, the continuous and stepped modes and their combination, each external-edge setting, stop mid-run, triggers while busy, and a consumer that stalls the port. The stalled-consumer runs, with and without auto-wait, show whether overrun detection and the keep/overwrite choice are correct.

// File: rtl/rgscan_pkg.sv
package rgscan_pkg;

  localparam int HALF_W = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CONV = 2'd2,
    ST_HOLD = 2'd3
  } seq_state_e;

  // sampling length in half clocks
  function automatic logic [HALF_W-1:0] samp_halves(input logic [2:0] code);
    logic [HALF_W-1:0] v;
    case (code)
      3'd0: v = 10'd3;
      3'd1: v = 10'd15;
      3'd2: v = 10'd27;
      3'd3: v = 10'd57;
      3'd4: v = 10'd83;
      3'd5: v = 10'd111;
      3'd6: v = 10'd143;
      default: v = 10'd479;
    endcase
    return v;
  endfunction

  // processing length in half clocks, by resolution code
  function automatic logic [HALF_W-1:0] proc_halves(input logic [1:0] res);
    logic [HALF_W-1:0] v;
    case (res)
      2'd0: v = 10'd25;
      2'd1: v = 10'd21;
      2'd2: v = 10'd17;
      default: v = 10'd13;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rgscan_trig.sv
module rgscan_trig (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_trig,
  input  logic [1:0] edge_sel,
  input  logic       sw_start,
  output logic       fire
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= ext_trig;
  end

  assign rise = ext_trig & ~prev_q;
  assign fall = ~ext_trig & prev_q;
  assign fire = sw_start | (edge_sel[0] & rise) | (edge_sel[1] & fall);
endmodule

// File: rtl/rgscan_pick.sv
module rgscan_pick #(
  parameter int NCH = 19,
  parameter int CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  cur,
  input  logic           back,
  output logic [CW-1:0]  first_idx,
  output logic [CW-1:0]  next_idx,
  output logic           has_next
);
  logic [NCH-1:0] above, below, cand;

  for (genvar b = 0; b < NCH; b++) begin : g_side
    assign above[b] = mask[b] && (CW'(b) > cur);
    assign below[b] = mask[b] && (CW'(b) < cur);
  end

  assign cand = back ? below : above;

  always_comb begin
    first_idx = '0;
    next_idx  = '0;
    has_next  = 1'b0;
    if (back) begin
      // highest index wins: later assignments override
      for (int i = 0; i < NCH; i++) begin
        if (mask[i]) first_idx = CW'(i);
        if (cand[i]) begin
          next_idx = CW'(i);
          has_next = 1'b1;
        end
      end
    end else begin
      // lowest index wins
      for (int i = NCH - 1; i >= 0; i--) begin
        if (mask[i]) first_idx = CW'(i);
        if (cand[i]) begin
          next_idx = CW'(i);
          has_next = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rgscan_timer.sv
module rgscan_timer #(
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  localparam logic [HW-1:0] STEP = HW'(2);
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (run && cnt_q > STEP)  cnt_q <= cnt_q - STEP;
  end

  assign done = run && (cnt_q <= STEP);
endmodule

// File: rtl/rgscan_result.sv
module rgscan_result #(
  parameter int DW = 12,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic [CW-1:0] cap_chan,
  input  logic          keep_old,
  input  logic          dout_ready,
  output logic [DW-1:0] dout_data,
  output logic [CW-1:0] dout_chan,
  output logic          dout_valid,
  output logic          ovr
);
  logic taken;
  assign taken = dout_valid & dout_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_data  <= '0;
      dout_chan  <= '0;
      dout_valid <= 1'b0;
      ovr        <= 1'b0;
    end else begin
      ovr <= 1'b0;
      if (cap) begin
        dout_valid <= 1'b1;
        if (dout_valid && !taken) begin
          ovr <= 1'b1;
          if (!keep_old) begin
            dout_data <= cap_data;
            dout_chan <= cap_chan;
          end
        end else begin
          dout_data <= cap_data;
          dout_chan <= cap_chan;
        end
      end else if (taken) begin
        dout_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rgscan_top.sv
module rgscan_top #(
  parameter int NCH = 19,
  parameter int DW  = 12,
  parameter int HW  = 10,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_mask,
  input  logic           scan_back,
  input  logic           cont_mode,
  input  logic           disc_mode,
  input  logic [1:0]     trig_edge,
  input  logic [1:0]     res_sel,
  input  logic [2:0]     samp_sel,
  input  logic           auto_wait,
  input  logic           ovr_keep,
  input  logic           sw_start,
  input  logic           ext_trig,
  input  logic           stop_req,
  output logic           conv_start,
  output logic [CW-1:0]  conv_chan,
  input  logic [DW-1:0]  conv_result,
  output logic [DW-1:0]  dout_data,
  output logic [CW-1:0]  dout_chan,
  output logic           dout_valid,
  input  logic           dout_ready,
  output logic           eoc,
  output logic           eos,
  output logic           ovr,
  output logic           busy
);
  import rgscan_pkg::*;

  seq_state_e     state_q, state_d;
  logic [NCH-1:0] mask_q, pick_mask;
  logic           back_q, pick_back;
  logic [CW-1:0]  cur_q, cur_d;
  logic [CW-1:0]  first_idx, next_idx;
  logic           has_next;
  logic           fire, launch, done, stop_now, stop_pend_q;
  logic [HW-1:0]  conv_len;
  logic [DW-1:0]  res_mask;
  logic           eoc_q, eos_q;

  rgscan_trig u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_trig (ext_trig),
    .edge_sel (trig_edge),
    .sw_start (sw_start),
    .fire     (fire)
  );

  // in idle the live config picks the first rank; during a run the latched copy is used
  assign pick_mask = (state_q == ST_IDLE) ? chan_mask : mask_q;
  assign pick_back = (state_q == ST_IDLE) ? scan_back : back_q;

  rgscan_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .mask      (pick_mask),
    .cur       (cur_q),
    .back      (pick_back),
    .first_idx (first_idx),
    .next_idx  (next_idx),
    .has_next  (has_next)
  );

  assign conv_len = HW'(samp_halves(samp_sel)) + HW'(proc_halves(res_sel));

  rgscan_timer #(.HW(HW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .load_val (conv_len),
    .run      (state_q == ST_CONV),
    .done     (done)
  );

  assign res_mask = {DW{1'b1}} >> {res_sel, 1'b0};

  rgscan_result #(.DW(DW), .CW(CW)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (done),
    .cap_data   (conv_result & res_mask),
    .cap_chan   (cur_q),
    .keep_old   (ovr_keep),
    .dout_ready (dout_ready),
    .dout_data  (dout_data),
    .dout_chan  (dout_chan),
    .dout_valid (dout_valid),
    .ovr        (ovr)
  );

  assign stop_now = stop_req | stop_pend_q;
  assign launch   = (state_q == ST_ARM) && !stop_now && !(auto_wait && dout_valid);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    case (state_q)
      ST_IDLE: begin
        if (fire && (|chan_mask)) begin
          state_d = ST_ARM;
          cur_d   = first_idx;
        end
      end
      ST_ARM: begin
        if (stop_now)    state_d = ST_IDLE;
        else if (launch) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (done) begin
          if (stop_now) begin
            state_d = ST_IDLE;
          end else if (!has_next) begin
            if (cont_mode) begin
              state_d = ST_ARM;
              cur_d   = first_idx;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cur_d   = next_idx;
            state_d = (disc_mode && !cont_mode) ? ST_HOLD : ST_ARM;
          end
        end
      end
      default: begin
        if (stop_now)  state_d = ST_IDLE;
        else if (fire) state_d = ST_ARM;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      mask_q      <= '0;
      back_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      eoc_q       <= 1'b0;
      eos_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      if (state_q == ST_IDLE) begin
        mask_q <= chan_mask;
        back_q <= scan_back;
      end
      if (state_d == ST_IDLE)  stop_pend_q <= 1'b0;
      else if (stop_req)       stop_pend_q <= 1'b1;
      eoc_q <= done;
      eos_q <= done && !has_next;
    end
  end

  assign conv_start = launch;
  assign conv_chan  = cur_q;
  assign eoc        = eoc_q;
  assign eos        = eos_q;
  assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/rgscan_chk.sv
module rgscan_chk #(
  parameter int DW = 12,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic [CW-1:0] conv_chan,
  input logic [DW-1:0] dout_data,
  input logic [CW-1:0] dout_chan,
  input logic          dout_valid,
  input logic          dout_ready,
  input logic          ovr_keep,
  input logic          auto_wait,
  input logic          eoc,
  input logic          eos,
  input logic          ovr,
  input logic          busy
);
  assert_start_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_chan_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> $stable(conv_chan));

  assert_no_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_start);

  assert_autowait_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && auto_wait) |-> !dout_valid);

  assert_ovr_with_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> dout_valid);

  assert_keep_holds_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready && ovr_keep) |=> (dout_valid && $stable(dout_data) && $stable(dout_chan)));

  assert_eos_has_eoc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> eoc);

  assert_eoc_has_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> dout_valid);
endmodule

bind rgscan_top rgscan_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .dout_data  (dout_data),
  .dout_chan  (dout_chan),
  .dout_valid (dout_valid),
  .dout_ready (dout_ready),
  .ovr_keep   (ovr_keep),
  .auto_wait  (auto_wait),
  .eoc        (eoc),
  .eos        (eos),
  .ovr        (ovr),
  .busy       (busy)
);

// File: tb/rgscan_top_tb.sv
`timescale 1ns/1ps
module rgscan_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] chan_mask = '0;
  logic        scan_back = 1'b0, cont_mode = 1'b0, disc_mode = 1'b0;
  logic [1:0]  trig_edge = 2'd0, res_sel = 2'd0;
  logic [2:0]  samp_sel = 3'd0;
  logic        auto_wait = 1'b0, ovr_keep = 1'b0;
  logic        sw_start = 1'b0, ext_trig = 1'b0, stop_req = 1'b0;
  logic        conv_start;
  logic [4:0]  conv_chan, dout_chan;
  logic [11:0] conv_result = 12'hABC, dout_data;
  logic        dout_valid, dout_ready = 1'b1;
  logic        eoc, eos, ovr, busy;

  always #2.5 clk = ~clk;

  rgscan_top u_dut (
    .clk(clk), .rst_n(rst_n), .chan_mask(chan_mask), .scan_back(scan_back),
    .cont_mode(cont_mode), .disc_mode(disc_mode), .trig_edge(trig_edge),
    .res_sel(res_sel), .samp_sel(samp_sel), .auto_wait(auto_wait),
    .ovr_keep(ovr_keep), .sw_start(sw_start), .ext_trig(ext_trig),
    .stop_req(stop_req), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_result(conv_result), .dout_data(dout_data), .dout_chan(dout_chan),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .eoc(eoc), .eos(eos),
    .ovr(ovr), .busy(busy)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int log_ch [0:1023];
  int log_n = 0, eos_n = 0, ovr_n = 0, lat_err = 0;
  int t_start = 0, exp_lat = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: eoc is handled before conv_start, since both may appear in one cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (eoc) begin
        if (log_n < 1024) log_ch[log_n] = int'(dout_chan);
        log_n++;
        if (cyc - t_start != exp_lat) lat_err++;
        if (eos) eos_n++;
      end
      if (ovr) ovr_n++;
      if (conv_start) t_start = cyc;
    end
  end

  function automatic int b_samp(int c);
    case (c)
      0: return 3;   1: return 15;  2: return 27;  3: return 57;
      4: return 83;  5: return 111; 6: return 143; default: return 479;
    endcase
  endfunction

  function automatic int b_lat(int s, int r);
    return (b_samp(s) + 25 - 4 * r) / 2 + 1;
  endfunction

  function automatic int b_order(logic [18:0] m, bit back, int k);
    int n = 0;
    for (int j = 0; j < 19; j++) begin
      int ch = back ? 18 - j : j;
      if (m[ch]) begin
        if (n == k) return ch;
        n++;
      end
    end
    return -1;
  endfunction

  function automatic int b_data(logic [11:0] raw, int r);
    return int'(raw & (12'hFFF >> (2 * r)));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_pulse();
    sw_start = 1'b1; tick(1); sw_start = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 20000) begin tick(1); k++; end
    tick(1);
  endtask

  task automatic set_cfg(input logic [18:0] m, input bit bk, input int s, input int r);
    chan_mask = m; scan_back = bk; samp_sel = 3'(s); res_sel = 2'(r);
    exp_lat = b_lat(s, r);
  endtask

  task automatic run_pass(input string tag, input logic [18:0] m, input bit bk);
    int base = log_n, e0 = eos_n, l0 = lat_err, cnt = $countones(m);
    start_pulse();
    wait_idle();
    chk(log_n - base == cnt, {tag, " rank count"}, log_n - base, cnt);
    for (int k = 0; k < cnt; k++)
      chk(log_ch[base + k] == b_order(m, bk, k), {tag, " rank order"}, log_ch[base + k], b_order(m, bk, k));
    chk(eos_n - e0 == 1, {tag, " R10 eos once"}, eos_n - e0, 1);
    chk(lat_err == l0, {tag, " R3 latency"}, lat_err - l0, 0);
    chk(dout_data == 12'(b_data(conv_result, int'(res_sel))), {tag, " R13 data"}, dout_data, b_data(conv_result, int'(res_sel)));
    chk(busy == 1'b0, {tag, " R4 idle after pass"}, busy, 0);
  endtask

  task automatic run_tests();
    int base, e0, o0, n0;
    void'($urandom(32'd20240611));
    tick(3); rst_n = 1'b1; tick(2);
    // reset state
    chk(!busy && !dout_valid && !eoc && !conv_start && !ovr, "R4 reset state", busy, 0);

    // R1 forward, R2 backward
    set_cfg(19'h40025, 1'b0, 0, 0); run_pass("R1 forward", 19'h40025, 1'b0);
    set_cfg(19'h40025, 1'b1, 1, 1); run_pass("R2 backward", 19'h40025, 1'b1);
    // R10 single channel
    set_cfg(19'h00080, 1'b0, 2, 2); run_pass("R10 single channel", 19'h00080, 1'b0);
    // R13 resolution
    conv_result = 12'hABC;
    set_cfg(19'h00010, 1'b0, 0, 2); run_pass("R13 8 bit", 19'h00010, 1'b0);
    chk(dout_data == 12'h0BC, "R13 8 bit value", dout_data, 12'h0BC);
    set_cfg(19'h00010, 1'b0, 0, 3); run_pass("R13 6 bit", 19'h00010, 1'b0);
    chk(dout_data == 12'h03C, "R13 6 bit value", dout_data, 12'h03C);

    // random passes, both directions
    for (int it = 0; it < 10; it++) begin
      logic [18:0] m = 19'($urandom());
      bit bk = 1'($urandom());
      if (m == '0) m = 19'h1;
      conv_result = 12'($urandom());
      set_cfg(m, bk, int'($urandom() % 8), int'($urandom() % 4));
      run_pass(bk ? "R2 random" : "R1 random", m, bk);
    end

    // R5 continuous, R12 stop
    set_cfg(19'h00003, 1'b0, 0, 3); cont_mode = 1'b1;
    base = log_n;
    start_pulse();
    while (log_n < base + 5) tick(1);
    stop_req = 1'b1; tick(1); stop_req = 1'b0;
    n0 = log_n;
    wait_idle();
    for (int k = 0; k < 4; k++)
      chk(log_ch[base + k] == (k % 2), "R5 continuous order", log_ch[base + k], k % 2);
    chk(log_n - n0 <= 1, "R12 stop at boundary", log_n - n0, 1);
    tick(30);
    chk(!busy && log_n - n0 <= 1, "R12 stays stopped", busy, 0);
    cont_mode = 1'b0;

    // R6 stepped mode
    set_cfg(19'h0001A, 1'b0, 0, 3); disc_mode = 1'b1;
    base = log_n; e0 = eos_n;
    start_pulse(); tick(30);
    chk(log_n - base == 1 && log_ch[base] == 1, "R6 first step", log_ch[base], 1);
    chk(busy == 1'b1, "R6 waits between steps", busy, 1);
    start_pulse(); tick(30);
    chk(log_n - base == 2 && log_ch[base + 1] == 3, "R6 second step", log_ch[base + 1], 3);
    start_pulse(); wait_idle();
    chk(log_n - base == 3 && log_ch[base + 2] == 4, "R6 third step", log_ch[base + 2], 4);
    chk(eos_n - e0 == 1, "R6 eos on last step", eos_n - e0, 1);
    // R6 stepped ignored under continuous
    cont_mode = 1'b1; chan_mask = 19'h00003;
    base = log_n;
    start_pulse(); tick(40);
    chk(log_n - base >= 3, "R6 ignored in continuous", log_n - base, 3);
    stop_req = 1'b1; tick(1); stop_req = 1'b0; wait_idle();
    cont_mode = 1'b0; disc_mode = 1'b0;

    // R7 external edges
    set_cfg(19'h00004, 1'b0, 0, 3);
    base = log_n;
    trig_edge = 2'd0; ext_trig = 1'b1; tick(3); ext_trig = 1'b0; tick(3);
    chk(busy == 1'b0 && log_n == base, "R7 edge none", busy, 0);
    trig_edge = 2'd1; ext_trig = 1'b1; tick(2);
    chk(busy == 1'b1, "R7 rising starts", busy, 1);
    wait_idle(); ext_trig = 1'b0; tick(3);
    chk(busy == 1'b0 && log_n - base == 1, "R7 rising ignores fall", log_n - base, 1);
    trig_edge = 2'd2; ext_trig = 1'b1; tick(3);
    chk(busy == 1'b0, "R7 falling ignores rise", busy, 0);
    ext_trig = 1'b0; tick(2);
    chk(busy == 1'b1, "R7 falling starts", busy, 1);
    wait_idle();
    trig_edge = 2'd3; ext_trig = 1'b1; tick(2);
    chk(busy == 1'b1, "R7 both on rise", busy, 1);
    wait_idle(); ext_trig = 1'b0; tick(2);
    chk(busy == 1'b1, "R7 both on fall", busy, 1);
    wait_idle(); trig_edge = 2'd0;

    // R14 trigger while busy, empty mask
    set_cfg(19'h00008, 1'b0, 7, 0);
    base = log_n;
    start_pulse(); tick(20); start_pulse(); wait_idle();
    chk(log_n - base == 1, "R14 busy trigger ignored", log_n - base, 1);
    chan_mask = '0; start_pulse(); tick(3);
    chk(busy == 1'b0, "R14 empty mask", busy, 0);

    // R9 overrun keep / overwrite, R11 hold
    set_cfg(19'h00003, 1'b0, 0, 3); dout_ready = 1'b0; ovr_keep = 1'b1;
    o0 = ovr_n;
    start_pulse(); wait_idle();
    chk(ovr_n - o0 == 1, "R9 overrun pulse", ovr_n - o0, 1);
    chk(dout_valid && dout_chan == 5'd0, "R9 keep old word", dout_chan, 0);
    tick(5);
    chk(dout_chan == 5'd0 && dout_valid, "R11 held while stalled", dout_chan, 0);
    dout_ready = 1'b1; tick(1); dout_ready = 1'b0; tick(1);
    chk(dout_valid == 1'b0, "R11 valid drops after take", dout_valid, 0);
    ovr_keep = 1'b0; o0 = ovr_n;
    start_pulse(); wait_idle();
    chk(ovr_n - o0 == 1 && dout_chan == 5'd1, "R9 overwrite", dout_chan, 1);
    dout_ready = 1'b1; tick(1); dout_ready = 1'b0; tick(1);

    // R8 auto-wait
    auto_wait = 1'b1; o0 = ovr_n; base = log_n;
    start_pulse();
    while (log_n < base + 1) tick(1);
    tick(40);
    chk(log_n - base == 1 && busy, "R8 held for read", log_n - base, 1);
    dout_ready = 1'b1; tick(1); dout_ready = 1'b0;
    wait_idle();
    chk(log_n - base == 2 && ovr_n == o0, "R8 resumes, no overrun", log_n - base, 2);
    auto_wait = 1'b0; dout_ready = 1'b1;
    tick(5);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule